// File: doc/BRIEF.md
# Graph-Colored Probabilistic-Bit Gibbs Sampler

This block holds a small bank of probabilistic bits that together represent one partition of a sparse Ising graph, and updates them by Gibbs sampling. Every bit has a bipolar state. On each update a bit forms a local field from a bias and from the weighted states of up to a fixed number of neighbours. It scales that field by an inverse temperature, passes it through a tanh lookup, and compares the result with its own pseudo-random number to pick its next state.

Bits carry a colour tag. Bits of one colour share no edges, so all of them update together in one cycle, and the colours are visited in order. A neighbour may be another local bit or a shadow register that holds the state of a bit owned by another partition. The weight of such a cross-partition edge is a local copy, so no weight ever enters through the data path.

Couplings, biases, neighbour sources and colour tags sit in local registers and are loaded through a simple write port while the sampler is stopped. While `run` is low the states are frozen and can be read from `state_out`. Each time a full pass over all colours completes, the block pulses `sweep_done` and increments `sweep_cnt`.

Top module: `pbit_sampler`

## Requirements
- R1: After reset every state reads -1 (`state_out` all zero), `sweep_done` is 0 and `sweep_cnt` is 0. In `state_out`, bit value 1 means +1 and 0 means -1.
- R2: A write with `cfg_we` high is applied only when `run` is low. `cfg_kind` selects the target: 0 writes weight `cfg_slot` of bit `cfg_idx`, 1 writes its bias, 2 writes the neighbour source of slot `cfg_slot`, and 3 writes its colour tag. A write issued while `run` is high has no effect.
- R3: The field of a bit equals its bias plus, for each slot, the slot weight when the source state is +1 or minus the weight when it is -1. The sum saturates to 16-bit signed. Weights and bias are 8-bit signed.
- R4: The scaled input x is (beta × field) arithmetically shifted right by 4, then clamped to [-128, 127]. The activation is trunc(4x(27648+x²)/(27648+9x²)) clamped to [-128, 128], so it reaches ±128 for |x| ≥ 96. The new state is +1 exactly when the activation exceeds a signed 8-bit random value, which makes |x| ≥ 96 deterministic, while x = 0 (for example beta = 0) gives +1 about half the time.
- R5: While `run` is high, exactly one colour is active per cycle. The colours start at 0 on the first running cycle and advance by one per cycle. Only bits whose tag equals the active colour may change, and they see the states held before that cycle.
- R6: In the cycle after the last colour (N_COLORS-1) is updated, `sweep_done` is high for one cycle and `sweep_cnt` has increased by one.
- R7: While `run` is low, `state_out` holds its value. The next run restarts at colour 0.
- R8: A neighbour source value below N_PBITS selects that local bit. A value from N_PBITS to N_PBITS+N_SHADOW-1 selects shadow register (value - N_PBITS). Larger values contribute nothing. A pulse on `shadow_ld` copies `shadow_val` into the shadow registers.
- R9: Each bit draws from its own 32-bit xorshift generator with a distinct nonzero seed, so two bits with zero field produce differing sequences, each near half +1.
- R10: A bit whose tag is N_COLORS or larger is never updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to sample, low to freeze and configure |
| beta | input | BETA_W | Unsigned inverse temperature |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: weight, bias, source, tag |
| cfg_idx | input | log2(N_PBITS) | Target bit |
| cfg_slot | input | log2(N_NBR) | Neighbour slot |
| cfg_data | input | W_W | Write value |
| shadow_ld | input | 1 | Load boundary states |
| shadow_val | input | N_SHADOW | Boundary states, 1 = +1 |
| state_out | output | N_PBITS | Current states, 1 = +1 |
| sweep_done | output | 1 | One-cycle pulse after a sweep |
| sweep_cnt | output | CNT_W | Completed sweeps |

## Verification
With two colours, the colour-0 bits take their new value at the first rising edge that samples `run` high, and the colour-1 bits take theirs one edge later. `sweep_done` and the incremented count are visible right after that second edge. The bench changes inputs only on falling edges and lowers `run` on the falling edge that follows the second update edge, where it reads states, pulse and count. It then reads again one falling edge later to confirm that the pulse has dropped. The stochastic requirements are checked by counting outcomes at each `sweep_done` over hundreds of sweeps against wide bounds.

// File: rtl/pbit_pkg.sv
package pbit_pkg;

   typedef enum logic [1:0] {
      CFG_WEIGHT = 2'd0,
      CFG_BIAS   = 2'd1,
      CFG_SRC    = 2'd2,
      CFG_TAG    = 2'd3
   } cfg_kind_e;

   localparam int LUT_BITS = 8;
   localparam int LUT_N    = 1 << LUT_BITS;
   localparam int ACT_W    = LUT_BITS + 1;

   // rational tanh approximation, input x = 32*t, output 128*tanh(t)
   function automatic int tanh_q(input int x);
      int num, den, q;
      num = 4 * x * (27648 + x * x);
      den = 27648 + 9 * x * x;
      q   = num / den;
      if (q > 128)  q = 128;
      if (q < -128) q = -128;
      return q;
   endfunction

   function automatic logic [31:0] xorshift32(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   function automatic logic [31:0] seed_of(input logic [31:0] base, input int idx);
      logic [31:0] s;
      s = base ^ (32'(idx + 1) * 32'h9E37_79B9);
      if (s == 32'h0) s = 32'h1;
      return s;
   endfunction

endpackage

// File: rtl/pbit_rng.sv
module pbit_rng #(
   parameter logic [31:0] SEED  = 32'h1,
   parameter int          OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [OUT_W-1:0] rnd
);
   logic [31:0] state_q;

   if (SEED == 32'h0 || OUT_W < 1 || OUT_W > 32) begin : g_bad
      $error("pbit_rng: seed must be nonzero and OUT_W within 1..32");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state_q <= SEED;
      else if (adv) state_q <= pbit_pkg::xorshift32(state_q);
   end

   assign rnd = state_q[31 -: OUT_W];

   // R9
   rng_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != 32'h0);
   // R9
   rng_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> state_q != $past(state_q));
endmodule

// File: rtl/pbit_field.sv
module pbit_field #(
   parameter int N_NBR = 4,
   parameter int N_SRC = 12,
   parameter int SRC_W = 5,
   parameter int W_W   = 8,
   parameter int ACC_W = 16
) (
   input  logic [W_W-1:0]                bias,
   input  logic [N_NBR-1:0][W_W-1:0]     wts,
   input  logic [N_NBR-1:0][SRC_W-1:0]   srcs,
   input  logic [N_SRC-1:0]              pool,
   output logic signed [ACC_W-1:0]       field
);
   localparam int SUM_W = ACC_W + $clog2(N_NBR + 1) + 1;
   localparam logic signed [SUM_W-1:0] F_MAX = SUM_W'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
   localparam logic signed [SUM_W-1:0] F_MIN = -F_MAX - SUM_W'(1);

   if (W_W > ACC_W) begin : g_bad
      $error("pbit_field: weight wider than accumulator");
   end

   logic signed [SUM_W-1:0] acc;

   always_comb begin
      acc = SUM_W'($signed(bias));
      for (int k = 0; k < N_NBR; k++) begin
         if (int'(srcs[k]) < N_SRC) begin
            if (pool[srcs[k]]) acc = acc + SUM_W'($signed(wts[k]));
            else               acc = acc - SUM_W'($signed(wts[k]));
         end
      end
      if (acc > F_MAX)      field = F_MAX[ACC_W-1:0];
      else if (acc < F_MIN) field = F_MIN[ACC_W-1:0];
      else                  field = acc[ACC_W-1:0];
   end
endmodule

// File: rtl/pbit_cell.sv
module pbit_cell #(
   parameter int          N_NBR      = 4,
   parameter int          N_SRC      = 12,
   parameter int          SRC_W      = 5,
   parameter int          W_W        = 8,
   parameter int          ACC_W      = 16,
   parameter int          BETA_W     = 8,
   parameter int          BETA_SHIFT = 4,
   parameter logic [31:0] SEED       = 32'h1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        upd,
   input  logic                        adv,
   input  logic [BETA_W-1:0]           beta,
   input  logic [W_W-1:0]              bias,
   input  logic [N_NBR-1:0][W_W-1:0]   wts,
   input  logic [N_NBR-1:0][SRC_W-1:0] srcs,
   input  logic [N_SRC-1:0]            pool,
   output logic                        state
);
   localparam int LB     = pbit_pkg::LUT_BITS;
   localparam int AW     = pbit_pkg::ACT_W;
   localparam int PROD_W = BETA_W + 1 + ACC_W;
   localparam logic signed [PROD_W-1:0] X_MAX = PROD_W'((1 << (LB - 1)) - 1);
   localparam logic signed [PROD_W-1:0] X_MIN = -X_MAX - PROD_W'(1);

   logic signed [ACC_W-1:0]  field;
   logic signed [PROD_W-1:0] prod, scaled;
   logic signed [LB-1:0]     x;
   logic [LB-1:0]            lut_idx;
   logic signed [AW-1:0]     act, rnd_ext;
   logic [LB-1:0]            rnd;
   logic signed [AW-1:0]     lut [pbit_pkg::LUT_N];
   logic                     state_q;

   pbit_field #(.N_NBR(N_NBR), .N_SRC(N_SRC), .SRC_W(SRC_W), .W_W(W_W), .ACC_W(ACC_W))
      u_field (.bias(bias), .wts(wts), .srcs(srcs), .pool(pool), .field(field));

   pbit_rng #(.SEED(SEED), .OUT_W(LB))
      u_rng (.clk(clk), .rst_n(rst_n), .adv(adv), .rnd(rnd));

   for (genvar k = 0; k < pbit_pkg::LUT_N; k++) begin : g_lut
      assign lut[k] = AW'(pbit_pkg::tanh_q(k - pbit_pkg::LUT_N / 2));
   end

   always_comb begin
      prod   = PROD_W'($signed({1'b0, beta})) * PROD_W'(field);
      scaled = prod >>> BETA_SHIFT;
      if (scaled > X_MAX)      x = X_MAX[LB-1:0];
      else if (scaled < X_MIN) x = X_MIN[LB-1:0];
      else                     x = scaled[LB-1:0];
      lut_idx = {~x[LB-1], x[LB-2:0]};
      act     = lut[lut_idx];
      rnd_ext = AW'($signed(rnd));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state_q <= 1'b0;
      else if (upd) state_q <= (act > rnd_ext);
   end

   assign state = state_q;

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(state_q));
   // R4
   sat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd && act == AW'(128) |=> state_q);
endmodule

// File: rtl/pbit_seq.sv
module pbit_seq #(
   parameter int N_COLORS = 2,
   parameter int CNT_W    = 16
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    run,
   output logic [(N_COLORS > 1 ? $clog2(N_COLORS) : 1)-1:0] color,
   output logic                                    sweep_done,
   output logic [CNT_W-1:0]                        sweep_cnt
);
   localparam int COL_W = (N_COLORS > 1) ? $clog2(N_COLORS) : 1;
   localparam logic [COL_W-1:0] LAST = COL_W'(N_COLORS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         color      <= '0;
         sweep_done <= 1'b0;
         sweep_cnt  <= '0;
      end else begin
         sweep_done <= 1'b0;
         if (!run) begin
            color <= '0;
         end else if (color == LAST) begin
            color      <= '0;
            sweep_done <= 1'b1;
            sweep_cnt  <= sweep_cnt + 1'b1;
         end else begin
            color <= color + 1'b1;
         end
      end
   end

   // R6
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done |-> $past(run) && $past(color) == LAST);
   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done |-> sweep_cnt == $past(sweep_cnt) + 1'b1);
   // R5
   color_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && color != LAST |=> color == $past(color) + 1'b1);
   // R7
   color_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> color == '0 && !sweep_done);
endmodule

// File: rtl/pbit_sampler.sv
module pbit_sampler #(
   parameter int          N_PBITS    = 8,
   parameter int          N_NBR      = 4,
   parameter int          N_COLORS   = 2,
   parameter int          N_SHADOW   = 4,
   parameter int          W_W        = 8,
   parameter int          ACC_W      = 16,
   parameter int          BETA_W     = 8,
   parameter int          BETA_SHIFT = 4,
   parameter int          TAG_W      = 4,
   parameter int          CNT_W      = 16,
   parameter logic [31:0] SEED_BASE  = 32'h2545_F491
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      run,
   input  logic [BETA_W-1:0]                         beta,
   input  logic                                      cfg_we,
   input  logic [1:0]                                cfg_kind,
   input  logic [$clog2(N_PBITS)-1:0]                cfg_idx,
   input  logic [(N_NBR > 1 ? $clog2(N_NBR) : 1)-1:0] cfg_slot,
   input  logic [W_W-1:0]                            cfg_data,
   input  logic                                      shadow_ld,
   input  logic [N_SHADOW-1:0]                       shadow_val,
   output logic [N_PBITS-1:0]                        state_out,
   output logic                                      sweep_done,
   output logic [CNT_W-1:0]                          sweep_cnt
);
   localparam int N_SRC = N_PBITS + N_SHADOW;
   localparam int SRC_W = $clog2(N_SRC) + 1;
   localparam int COL_W = (N_COLORS > 1) ? $clog2(N_COLORS) : 1;

   if (N_PBITS < 2 || N_NBR < 1 || N_COLORS < 1 || N_SHADOW < 1) begin : g_bad_size
      $error("pbit_sampler: bank, slot, colour and shadow counts must be positive");
   end
   if (SRC_W > W_W || TAG_W > W_W || TAG_W < COL_W) begin : g_bad_width
      $error("pbit_sampler: source or tag field does not fit the write data");
   end

   logic [N_PBITS-1:0][N_NBR-1:0][W_W-1:0]   wt_q;
   logic [N_PBITS-1:0][W_W-1:0]              bias_q;
   logic [N_PBITS-1:0][N_NBR-1:0][SRC_W-1:0] src_q;
   logic [N_PBITS-1:0][TAG_W-1:0]            tag_q;
   logic [N_SHADOW-1:0]                      shadow_q;
   logic [N_PBITS-1:0]                       st, upd;
   logic [N_SRC-1:0]                         pool;
   logic [COL_W-1:0]                         color;
   logic                                     cfg_ok;

   assign cfg_ok = cfg_we && !run && (int'(cfg_idx) < N_PBITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wt_q   <= '0;
         bias_q <= '0;
         src_q  <= '0;
         tag_q  <= '0;
      end else if (cfg_ok) begin
         case (pbit_pkg::cfg_kind_e'(cfg_kind))
            pbit_pkg::CFG_WEIGHT: wt_q[cfg_idx][cfg_slot]  <= cfg_data;
            pbit_pkg::CFG_BIAS:   bias_q[cfg_idx]          <= cfg_data;
            pbit_pkg::CFG_SRC:    src_q[cfg_idx][cfg_slot] <= cfg_data[SRC_W-1:0];
            pbit_pkg::CFG_TAG:    tag_q[cfg_idx]           <= cfg_data[TAG_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         shadow_q <= '0;
      else if (shadow_ld) shadow_q <= shadow_val;
   end

   pbit_seq #(.N_COLORS(N_COLORS), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(run),
      .color(color), .sweep_done(sweep_done), .sweep_cnt(sweep_cnt));

   assign pool = {shadow_q, st};

   for (genvar i = 0; i < N_PBITS; i++) begin : g_cell
      localparam logic [31:0] SEED = pbit_pkg::seed_of(SEED_BASE, i);
      assign upd[i] = run && (tag_q[i] == TAG_W'(color));
      pbit_cell #(
         .N_NBR(N_NBR), .N_SRC(N_SRC), .SRC_W(SRC_W), .W_W(W_W), .ACC_W(ACC_W),
         .BETA_W(BETA_W), .BETA_SHIFT(BETA_SHIFT), .SEED(SEED)
      ) u_cell (
         .clk(clk), .rst_n(rst_n), .upd(upd[i]), .adv(run), .beta(beta),
         .bias(bias_q[i]), .wts(wt_q[i]), .srcs(src_q[i]), .pool(pool),
         .state(st[i]));
   end

   assign state_out = st;

   // R2
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(wt_q) && $stable(bias_q) && $stable(src_q) && $stable(tag_q));
   // R7
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(st));
   // R8
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shadow_ld |=> $stable(shadow_q));
   // R5
   one_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> upd == '0);
endmodule

// File: tb/test_pbit_sampler.sv
module test_pbit_sampler;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [7:0]  beta = 8'd16;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_kind = '0;
   logic [2:0]  cfg_idx = '0;
   logic [1:0]  cfg_slot = '0;
   logic [7:0]  cfg_data = '0;
   logic        shadow_ld = 1'b0;
   logic [3:0]  shadow_val = '0;
   logic [7:0]  state_out;
   logic        sweep_done;
   logic [15:0] sweep_cnt;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;

   // {bias of bit 0, shadow[2:0], expected states[4:0]}
   localparam logic [15:0] VEC [6] = '{
      {8'h7F, 3'b000, 5'b00111},
      {8'h81, 3'b111, 5'b11000},
      {8'h7F, 3'b011, 5'b00011},
      {8'h7F, 3'b110, 5'b11111},
      {8'h81, 3'b101, 5'b01000},
      {8'h81, 3'b010, 5'b00100}
   };

   always #(CLK_PERIOD / 2) clk = ~clk;

   pbit_sampler i_pbit_sampler (
      .clk(clk), .rst_n(rst_n), .run(run), .beta(beta),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_slot(cfg_slot),
      .cfg_data(cfg_data), .shadow_ld(shadow_ld), .shadow_val(shadow_val),
      .state_out(state_out), .sweep_done(sweep_done), .sweep_cnt(sweep_cnt));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] k, input int idx, input int slot, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = k; cfg_idx = 3'(idx); cfg_slot = 2'(slot); cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_shadow(input logic [3:0] v);
      @(negedge clk);
      shadow_ld = 1'b1; shadow_val = v;
      @(negedge clk);
      shadow_ld = 1'b0;
   endtask

   task automatic do_sweep(output logic d1, output logic [15:0] c1, output logic d2);
      @(negedge clk) run = 1'b1;
      @(negedge clk);
      @(negedge clk);
      d1 = sweep_done; c1 = sweep_cnt; run = 1'b0;
      @(negedge clk);
      d2 = sweep_done;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      logic        d1, d2;
      logic [15:0] c1;
      logic [7:0]  snap;
      int ones6, ones7, diff67, ones0, nsw;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(state_out == 8'h00, "R1 states", state_out, 0);
      chk(sweep_done == 1'b0, "R1 sweep_done", sweep_done, 0);
      chk(sweep_cnt == 16'd0, "R1 sweep_cnt", sweep_cnt, 0);

      // R2 configuration: kinds 0 weight, 1 bias, 2 source, 3 tag
      cfg(2'd3, 0, 0, 8'd0);
      cfg(2'd3, 1, 0, 8'd1); cfg(2'd2, 1, 0, 8'd0);  cfg(2'd0, 1, 0, 8'd120);
      cfg(2'd3, 2, 0, 8'd1); cfg(2'd2, 2, 0, 8'd8);  cfg(2'd0, 2, 0, 8'h88);
      cfg(2'd3, 3, 0, 8'd0); cfg(2'd2, 3, 0, 8'd1);  cfg(2'd0, 3, 0, 8'd120);
      cfg(2'd3, 4, 0, 8'd1); cfg(2'd2, 4, 0, 8'd9);  cfg(2'd0, 4, 0, 8'd100);
      cfg(2'd2, 4, 1, 8'd10); cfg(2'd0, 4, 1, 8'd100); cfg(2'd1, 4, 0, 8'h9C);
      cfg(2'd3, 5, 0, 8'd3); cfg(2'd1, 5, 0, 8'h7F);  // R10 tag outside colours
      cfg(2'd2, 6, 0, 8'd15); cfg(2'd0, 6, 0, 8'h7F); // R8 out-of-range source adds nothing

      // vector table: R3 R4 R5 R6 R8 R10
      for (int v = 0; v < 6; v++) begin
         logic [15:0] e;
         e = VEC[v];
         cfg(2'd1, 0, 0, e[15:8]);
         load_shadow({1'b0, e[7:5]});
         do_sweep(d1, c1, d2);
         chk(state_out[0] == e[0], "R4 saturated bias", state_out[0], e[0]);
         chk(state_out[1] == e[1], "R3 local neighbour", state_out[1], e[1]);
         chk(state_out[2] == e[2], "R8 shadow neighbour", state_out[2], e[2]);
         chk(state_out[3] == e[3], "R5 colour order", state_out[3], e[3]);
         chk(state_out[4] == e[4], "R3 two-shadow sum", state_out[4], e[4]);
         chk(state_out[5] == 1'b0, "R10 unvisited tag", state_out[5], 0);
         chk(d1 == 1'b1, "R6 pulse", d1, 1);
         chk(c1 == 16'(v + 1), "R6 count", c1, v + 1);
         chk(d2 == 1'b0, "R6 pulse width", d2, 0);
      end

      // R2 write while running is ignored
      @(negedge clk) run = 1'b1;
      repeat (3) @(negedge clk);
      cfg_we = 1'b1; cfg_kind = 2'd1; cfg_idx = 3'd0; cfg_data = 8'h7F;
      @(negedge clk) cfg_we = 1'b0;
      repeat (4) @(negedge clk);
      run = 1'b0;
      do_sweep(d1, c1, d2);
      chk(state_out[0] == 1'b0, "R2 write during run", state_out[0], 0);

      // R7 frozen while stopped, R2 write while stopped
      snap = state_out;
      load_shadow(4'b1111);
      cfg(2'd1, 0, 0, 8'h7F);
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk(state_out == snap, "R7 frozen states", state_out, snap);
      end
      chk(sweep_done == 1'b0, "R7 no pulse when idle", sweep_done, 0);
      do_sweep(d1, c1, d2);
      chk(state_out[0] == 1'b1, "R2 write while stopped", state_out[0], 1);

      // R9 independent streams at zero field
      ones6 = 0; ones7 = 0; diff67 = 0; nsw = 0;
      @(negedge clk) run = 1'b1;
      for (int c = 0; c < 800; c++) begin
         @(negedge clk);
         if (sweep_done) begin
            nsw++;
            ones6 += int'(state_out[6]);
            ones7 += int'(state_out[7]);
            diff67 += int'(state_out[6] ^ state_out[7]);
         end
      end
      run = 1'b0;
      chk(nsw == 400, "R6 sweeps in long run", nsw, 400);
      chk(ones6 >= 140 && ones6 <= 260, "R9 bit 6 balance", ones6, 200);
      chk(ones7 >= 140 && ones7 <= 260, "R9 bit 7 balance", ones7, 200);
      chk(diff67 >= 100, "R9 streams differ", diff67, 200);

      // R4 beta of zero makes a strong bias random
      @(negedge clk) beta = 8'd0;
      ones0 = 0;
      @(negedge clk) run = 1'b1;
      for (int c = 0; c < 800; c++) begin
         @(negedge clk);
         if (sweep_done) ones0 += int'(state_out[0]);
      end
      run = 1'b0;
      chk(ones0 >= 140 && ones0 <= 260, "R4 beta zero", ones0, 200);
      @(negedge clk) beta = 8'd16;
      do_sweep(d1, c1, d2);
      chk(state_out[0] == 1'b1, "R4 beta restored", state_out[0], 1);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule